// File: doc/BRIEF.md
# DSP Control and Interrupt Register

This block is a single 16-bit control and status word that sits between a host processor and a DSP. The host uses it to hold the DSP in reset or halt, to raise an interrupt toward the DSP, and to service three interrupt sources: audio-output DMA, auxiliary-memory DMA and DSP DMA. Each source has a pending flag and an enable mask. The flags are cleared by writing one to them. The masks are ordinary read/write bits.

Each source signals an event with a one-cycle set pulse. The block combines the enabled pending flags into one level interrupt toward the host. The DSP side acknowledges a requested reset with a pulse, and after that pulse the reset bit reads back as zero. The block holds a DMA-busy status position, which always reads zero, and one spare bit that stores whatever the host writes. A write takes effect at the next clock edge, and the read word always shows the current register contents.

Top module: `dsp_ctl_reg`

## Requirements
- R1: After reset, rd_data reads 0x0004. Halt is set and every other bit is clear.
- R2: Bit positions counted from bit 0 are: reset request, DSP interrupt assert, halt, audio flag, audio mask, aux-memory flag, aux-memory mask, DSP-DMA flag, DSP-DMA mask, DMA busy, spare, init. Bits 15:12 are pad. Source 0 is audio, source 1 is aux memory and source 2 is DSP DMA; source i has its flag at bit 3+2i and its mask at bit 4+2i.
- R3: A one-cycle pulse on set_pulse[i] sets flag i, and the flag is visible from the next cycle on.
- R4: A write with a one in a flag position clears that flag. A zero in that position leaves the flag unchanged.
- R5: If set_pulse[i] and a write-one-to-clear of flag i fall in the same cycle, the flag ends up set.
- R6: Every write loads the mask bits, the halt, assert, spare and init bits directly from wr_data.
- R7: The busy bit (bit 9) and the pad bits (15:12) always read zero, whatever the host writes.
- R8: A write with bit 0 set sets the reset request, and a write with bit 0 clear has no effect on it. A reset_ack pulse clears the request, unless a write with bit 0 set falls in the same cycle, in which case the request stays set.
- R9: irq_out is high exactly when some source has both its flag and its mask set.
- R10: dsp_reset_req, dsp_irq_assert and dsp_halt equal bits 0, 1 and 2 of the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 16 | Host write word |
| rd_data | output | 16 | Current register word |
| set_pulse | input | 3 | Per-source interrupt set pulse (0 audio, 1 aux memory, 2 DSP DMA) |
| reset_ack | input | 1 | DSP reset acknowledge pulse |
| irq_out | output | 1 | Combined interrupt to the host |
| dsp_reset_req | output | 1 | Reset request to the DSP |
| dsp_irq_assert | output | 1 | Interrupt toward the DSP |
| dsp_halt | output | 1 | Halt to the DSP |

## Verification
Two pairs of events can land in the same cycle: a source's set pulse together with a host write-one-to-clear of that flag, and a reset acknowledge together with a host write that sets the reset request. The bench forces both collisions in directed phases. It then keeps producing them in a long random phase, where writes, pulses and acknowledges are driven independently each cycle. A behavioural model in the bench applies the priority rules and is compared with the read word and all outputs on every cycle. In each collision the set is expected to win.

// File: rtl/dsp_ctl_pkg.sv
package dsp_ctl_pkg;
  localparam int WORD_W   = 16;
  localparam int NUM_SRC  = 3;
  localparam int B_RSTREQ = 0;
  localparam int B_ASSERT = 1;
  localparam int B_HALT   = 2;
  localparam int B_BUSY   = 9;
  localparam int B_SPARE  = 10;
  localparam int B_INIT   = 11;
  localparam int PAD_LO   = 12;
  localparam logic [WORD_W-1:0] RESET_WORD = WORD_W'(1) << B_HALT;

  function automatic int flag_pos(input int src);
    return 3 + 2 * src;
  endfunction

  function automatic int mask_pos(input int src);
    return 4 + 2 * src;
  endfunction

  function automatic logic any_enabled(input logic [NUM_SRC-1:0] flags,
                                       input logic [NUM_SRC-1:0] masks);
    return |(flags & masks);
  endfunction
endpackage

// File: rtl/dsp_irq_slot.sv
module dsp_irq_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic wr_en,
  input  logic mask_wr_val,
  output logic flag_o,
  output logic mask_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_o <= 1'b0;
      mask_o <= 1'b0;
    end else begin
      if (set_i)      flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
      if (wr_en)      mask_o <= mask_wr_val;
    end
  end
endmodule

// File: rtl/dsp_ctl_core.sv
module dsp_ctl_core (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_rst,
  input  logic wr_assert,
  input  logic wr_halt,
  input  logic wr_spare,
  input  logic wr_init,
  input  logic reset_ack,
  output logic rst_req_q,
  output logic assert_q,
  output logic halt_q,
  output logic spare_q,
  output logic init_q
);
  logic rst_set;
  assign rst_set = wr_en & wr_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req_q <= 1'b0;
      assert_q  <= 1'b0;
      halt_q    <= 1'b1;
      spare_q   <= 1'b0;
      init_q    <= 1'b0;
    end else begin
      if (rst_set)        rst_req_q <= 1'b1;
      else if (reset_ack) rst_req_q <= 1'b0;
      if (wr_en) begin
        assert_q <= wr_assert;
        halt_q   <= wr_halt;
        spare_q  <= wr_spare;
        init_q   <= wr_init;
      end
    end
  end
endmodule

// File: rtl/dsp_ctl_readback.sv
module dsp_ctl_readback
  import dsp_ctl_pkg::*;
(
  input  logic               rst_req_q,
  input  logic               assert_q,
  input  logic               halt_q,
  input  logic               spare_q,
  input  logic               init_q,
  input  logic [NUM_SRC-1:0] flags,
  input  logic [NUM_SRC-1:0] masks,
  output logic [WORD_W-1:0]  word_o
);
  always_comb begin
    word_o           = '0;
    word_o[B_RSTREQ] = rst_req_q;
    word_o[B_ASSERT] = assert_q;
    word_o[B_HALT]   = halt_q;
    for (int s = 0; s < NUM_SRC; s++) begin
      word_o[flag_pos(s)] = flags[s];
      word_o[mask_pos(s)] = masks[s];
    end
    word_o[B_BUSY]   = 1'b0;
    word_o[B_SPARE]  = spare_q;
    word_o[B_INIT]   = init_q;
  end
endmodule

// File: rtl/dsp_ctl_reg.sv
module dsp_ctl_reg
  import dsp_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  input  logic [NUM_SRC-1:0] set_pulse,
  input  logic              reset_ack,
  output logic              irq_out,
  output logic              dsp_reset_req,
  output logic              dsp_irq_assert,
  output logic              dsp_halt
);
  logic [NUM_SRC-1:0] flags, masks, clr_hit, collide;
  logic rst_req_q, assert_q, halt_q, spare_q, init_q;
  logic unused_wr_bits;

  assign unused_wr_bits = ^{wr_data[WORD_W-1:PAD_LO], wr_data[B_BUSY]};

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    localparam int FP = flag_pos(g);
    localparam int MP = mask_pos(g);
    assign clr_hit[g] = wr_en & wr_data[FP];
    assign collide[g] = clr_hit[g] & set_pulse[g];
    dsp_irq_slot u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_i      (set_pulse[g]),
      .clr_i      (clr_hit[g]),
      .wr_en      (wr_en),
      .mask_wr_val(wr_data[MP]),
      .flag_o     (flags[g]),
      .mask_o     (masks[g])
    );
  end

  dsp_ctl_core u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_rst   (wr_data[B_RSTREQ]),
    .wr_assert(wr_data[B_ASSERT]),
    .wr_halt  (wr_data[B_HALT]),
    .wr_spare (wr_data[B_SPARE]),
    .wr_init  (wr_data[B_INIT]),
    .reset_ack(reset_ack),
    .rst_req_q(rst_req_q),
    .assert_q (assert_q),
    .halt_q   (halt_q),
    .spare_q  (spare_q),
    .init_q   (init_q)
  );

  dsp_ctl_readback u_rb (
    .rst_req_q(rst_req_q),
    .assert_q (assert_q),
    .halt_q   (halt_q),
    .spare_q  (spare_q),
    .init_q   (init_q),
    .flags    (flags),
    .masks    (masks),
    .word_o   (rd_data)
  );

  assign irq_out        = any_enabled(flags, masks);
  assign dsp_reset_req  = rst_req_q;
  assign dsp_irq_assert = assert_q;
  assign dsp_halt       = halt_q;
endmodule

// File: rtl/dsp_ctl_reg_chk.sv
module dsp_ctl_reg_chk
  import dsp_ctl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [WORD_W-1:0] wr_data,
  input logic [WORD_W-1:0] rd_data,
  input logic [NUM_SRC-1:0] set_pulse,
  input logic              reset_ack,
  input logic              irq_out,
  input logic [NUM_SRC-1:0] clr_hit,
  input logic [NUM_SRC-1:0] collide
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
    localparam int FP = flag_pos(g);
    localparam int MP = mask_pos(g);

    a_r3_set_flag: assert property (@(posedge clk) disable iff (!rst_n)
      set_pulse[g] |=> rd_data[FP]);

    a_r4_clear_flag: assert property (@(posedge clk) disable iff (!rst_n)
      clr_hit[g] && !set_pulse[g] |=> !rd_data[FP]);

    a_r4_keep_flag: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_hit[g] && !set_pulse[g] |=> $stable(rd_data[FP]));

    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      collide[g] |=> rd_data[FP]);

    a_r6_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> rd_data[MP] == $past(wr_data[MP]));
  end

  a_r7_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[B_BUSY] == 1'b0 && rd_data[WORD_W-1:PAD_LO] == '0);

  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    reset_ack && !(wr_en && wr_data[B_RSTREQ]) |=> !rd_data[B_RSTREQ]);

  a_r8_write_sets: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_data[B_RSTREQ] |=> rd_data[B_RSTREQ]);

  a_r9_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == ((rd_data[3] & rd_data[4]) | (rd_data[5] & rd_data[6]) |
                (rd_data[7] & rd_data[8])));
endmodule

bind dsp_ctl_reg dsp_ctl_reg_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .rd_data  (rd_data),
  .set_pulse(set_pulse),
  .reset_ack(reset_ack),
  .irq_out  (irq_out),
  .clr_hit  (clr_hit),
  .collide  (collide)
);

// File: tb/dsp_ctl_reg_test.sv
`timescale 1ns/1ps
module dsp_ctl_reg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [2:0]  set_pulse = '0;
  logic        reset_ack = 1'b0;
  logic        irq_out, dsp_reset_req, dsp_irq_assert, dsp_halt;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  logic [15:0] model = 16'h0004;

  always #2.5 clk = ~clk;

  dsp_ctl_reg uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .set_pulse(set_pulse), .reset_ack(reset_ack),
    .irq_out(irq_out), .dsp_reset_req(dsp_reset_req),
    .dsp_irq_assert(dsp_irq_assert), .dsp_halt(dsp_halt)
  );

  // Reference model: priorities taken from the requirements
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model <= 16'h0004;
    else begin
      logic [15:0] n;
      n = model;
      for (int s = 0; s < 3; s++) begin
        if (set_pulse[s]) n[3 + 2*s] = 1'b1;                 // R3, R5
        else if (wr_en && wr_data[3 + 2*s]) n[3 + 2*s] = 1'b0; // R4
        if (wr_en) n[4 + 2*s] = wr_data[4 + 2*s];            // R6
      end
      if (wr_en) begin
        n[1] = wr_data[1]; n[2] = wr_data[2];
        n[10] = wr_data[10]; n[11] = wr_data[11];
      end
      if (wr_en && wr_data[0]) n[0] = 1'b1;                  // R8
      else if (reset_ack) n[0] = 1'b0;
      model <= n;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic compare_all();
    logic exp_irq;
    exp_irq = 1'b0;
    for (int s = 0; s < 3; s++)
      if (model[3 + 2*s] && model[4 + 2*s]) exp_irq = 1'b1;
    chk("R3/R4/R5 flags", rd_data & 16'h00A8, model & 16'h00A8);
    chk("R2/R6 stored bits", rd_data & 16'h0D56, model & 16'h0D56);
    chk("R7 busy and pad", rd_data & 16'hF200, 16'h0000);
    chk("R8 reset request", {15'd0, rd_data[0]}, {15'd0, model[0]});
    chk("R9 irq_out", {15'd0, irq_out}, {15'd0, exp_irq});
    chk("R10 side outputs", {13'd0, dsp_halt, dsp_irq_assert, dsp_reset_req},
        {13'd0, model[2], model[1], model[0]});
  endtask

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n) compare_all();
  end

  task automatic step(input logic we, input logic [15:0] d, input logic [2:0] sp, input logic ack);
    @(negedge clk);
    #0.5;
    wr_en = we; wr_data = d; set_pulse = sp; reset_ack = ack;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 16'h0000, 3'b000, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 reset word", rd_data, 16'h0004);
    // R3: each source sets its flag
    step(1'b0, 16'h0, 3'b001, 1'b0);
    step(1'b0, 16'h0, 3'b010, 1'b0);
    step(1'b0, 16'h0, 3'b100, 1'b0);
    idle(2);
    // R9: enable masks, keep flags (zeros in flag positions)
    step(1'b1, 16'h0150, 3'b000, 1'b0);
    idle(1);
    // R4: clear only the aux-memory flag
    step(1'b1, 16'h0170, 3'b000, 1'b0);
    idle(1);
    // R5: set and clear collide on audio source
    step(1'b1, 16'h0158, 3'b001, 1'b0);
    idle(1);
    // R7: write all ones, busy and pad stay zero; R6 loads stored bits
    step(1'b1, 16'hFFFF, 3'b000, 1'b0);
    idle(1);
    // R8: zero write no effect, ack clears, ack with set write keeps
    step(1'b1, 16'h0004, 3'b000, 1'b0);
    step(1'b0, 16'h0, 3'b000, 1'b1);
    step(1'b1, 16'h0001, 3'b000, 1'b0);
    step(1'b1, 16'h0001, 3'b000, 1'b1);
    idle(2);
    // random phase with frequent collisions
    for (int i = 0; i < 3000; i++)
      step(($urandom % 3) == 0, 16'($urandom), 3'($urandom) & 3'($urandom), ($urandom % 4) == 0);
    // R1: reset in the middle of activity
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    wr_en = 1'b0; set_pulse = '0; reset_ack = 1'b0;
    @(negedge clk); #1;
    chk("R1 reset word after run", rd_data, 16'h0004);
    idle(2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule